// File: doc/BRIEF.md
# Dual-Port Radio Frame Buffer with Underrun Detection

This block stores one radio frame of up to 128 bytes and makes it reachable from two independent sides at once. The host side has a write stream and a read stream. The radio side has a receive write stream and a transmit read stream. Both sides may move a byte in the same clock cycle. The first byte of every frame written on either side is its length field. Each access keeps its own byte pointer. The pointer returns to address 0 whenever a new access is started, and it then advances by one for each byte moved.

The block raises an underrun event in two cases. The first is a radio reception that begins while the host is reading the stored frame. The second is a frame that is too long: its length field is above 127, or a 129th byte is written. An underrun event gives a one-cycle interrupt pulse and sets a sticky flag, which the host clears with a strobe. Two inputs stop received bytes from being stored: a protect level, used while the radio is parked after a reception, and an acknowledgement-wait level. Received bytes are still accepted and consumed in both cases, so the stored frame is left intact.

In sleep the block refuses every transfer, closes all open accesses and forgets the stored frame. Reset does the same. A forgotten or over-length frame reads back as zero bytes. Other changes of the radio state have no effect on the stored frame.

Top module: `frame_buffer_dp`

## Requirements
- R1: Bytes written on the host write stream after a start strobe are stored at addresses 0, 1, 2 and so on. A host read session reads them back in the same order. Byte 0 is the length field.
- R2: The host read session and the radio transmit read session can run in the same cycles. Each returns the stored frame from its own pointer.
- R3: Back-pressure rules. A write stream is ready only while its access is open (a start strobe in this cycle or an earlier one) and sleep is low. A read stream is valid only while its session is open (opened by a start strobe, closed by a stop strobe) and sleep is low. A byte moves on a cycle in which valid and ready are both high.
- R4: A radio receive start that is not blocked, arriving while a host read session is open, gives an underrun interrupt pulse in the next cycle.
- R5: An over-length write raises the underrun interrupt and marks the frame invalid. Over-length means a length field above 127 (bit 7 set), or a byte accepted at address 128 or beyond. Such a byte is not stored.
- R6: The interrupt is high for one cycle per cycle that holds an underrun event. It sets a sticky flag that stays high until the clear strobe. A new event in the same cycle as the clear wins.
- R7: While protect is high, received bytes are accepted but not stored, and the stored frame is unchanged.
- R8: Protect has no effect on host writes.
- R9: While acknowledgement-wait is high, received bytes are accepted but not stored, and the stored frame is unchanged.
- R10: While sleep is high, no stream is ready or valid and every open access is closed. Afterwards the stored frame is invalid.
- R11: After reset, and whenever the frame is invalid, both read streams return 0x00. The underrun flag is low after reset.
- R12: A new start strobe during an open write access returns that pointer to address 0. Bytes beyond the new frame keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep level; refuses access and forgets the frame |
| protect_i | input | 1 | Blocks storage of received bytes |
| ackwait_i | input | 1 | Acknowledgement wait; blocks storage of received bytes |
| hw_start_i | input | 1 | Opens a host write access at address 0 |
| hw_valid_i | input | 1 | Host write byte valid |
| hw_ready_o | output | 1 | Host write byte accepted |
| hw_data_i | input | 8 | Host write byte |
| hr_start_i | input | 1 | Opens a host read session at address 0 |
| hr_stop_i | input | 1 | Closes the host read session |
| hr_valid_o | output | 1 | Host read byte valid |
| hr_ready_i | input | 1 | Host read byte taken |
| hr_data_o | output | 8 | Host read byte |
| rx_start_i | input | 1 | Opens a radio receive access at address 0 |
| rx_valid_i | input | 1 | Received byte valid |
| rx_ready_o | output | 1 | Received byte accepted |
| rx_data_i | input | 8 | Received byte |
| tx_start_i | input | 1 | Opens a radio transmit read session at address 0 |
| tx_stop_i | input | 1 | Closes the transmit read session |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Transmit byte taken |
| tx_data_o | output | 8 | Transmit byte |
| ur_clr_i | input | 1 | Clears the sticky underrun flag |
| ur_irq_o | output | 1 | One-cycle underrun interrupt |
| ur_flag_o | output | 1 | Sticky underrun flag |

## Verification
The store-and-return path is tried three ways. Random frames of random length go in through host writes or through unblocked receptions and come back through the host read or the transmit read; this separates the two write paths from the two read paths. Directed runs open both read sessions in the same cycles, restart a write part way through a frame, and send length fields of 127 and 128 and a 129-byte frame; these show whether pointers reset and whether the over-length limit is placed exactly. Receptions under protect, under acknowledgement wait, during an open host read and around sleep show whether each blocking or invalidating condition acts alone and whether it touches the host write path.

// File: rtl/fb_pkg.sv
package fb_pkg;
  // Result of one write port in one cycle.
  typedef struct packed {
    logic we;     // byte is stored
    logic first;  // stored byte is the length field
    logic ovf;    // over-length byte seen
  } wr_evt_t;
endpackage

// File: rtl/fb_wr_port.sv
module fb_wr_port #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          start,
  input  logic          valid,
  output logic          ready,
  input  logic [DW-1:0] data,
  input  logic          keep,
  output fb_pkg::wr_evt_t evt,
  output logic [AW-1:0] addr
);
  localparam logic [AW:0]   FULL    = (AW+1)'(DEPTH);
  localparam logic [DW-1:0] MAX_LEN = DW'(DEPTH - 1);

  logic          active;
  logic [AW:0]   cnt;
  logic [AW:0]   eff;
  logic          fire;
  logic          over;

  always_comb begin
    eff   = start ? '0 : cnt;
    ready = !sleep && (active || start);
    fire  = valid && ready;
    over  = (eff == FULL) || ((eff == '0) && (data > MAX_LEN));
    evt.we    = fire && keep && !over;
    evt.ovf   = fire && keep && over;
    evt.first = evt.we && (eff == '0);
    addr      = eff[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (sleep) begin
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      if (start) active <= 1'b1;
      if (fire) begin
        if (eff != FULL) cnt <= eff + 1'b1;
        else             cnt <= eff;
      end else if (start) begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/fb_rd_port.sv
module fb_rd_port #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          start,
  input  logic          stop,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] addr
);
  logic active;

  assign valid = active && !sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      addr   <= '0;
    end else if (sleep) begin
      active <= 1'b0;
      addr   <= '0;
    end else if (start) begin
      active <= 1'b1;
      addr   <= '0;
    end else if (stop) begin
      active <= 1'b0;
    end else if (valid && ready) begin
      addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/fb_store.sv
module fb_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  // port A (lower priority on same-address collision)
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_data,
  // port B (wins a same-address collision)
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_data,
  input  logic          frame_ok,
  input  logic [AW-1:0] raddr [NRD],
  output logic [DW-1:0] rdata [NRD]
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_data;
    if (b_we) mem[b_addr] <= b_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = frame_ok ? mem[raddr[g]] : '0;
  end
endmodule

// File: rtl/fb_underrun.sv
module fb_underrun #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            clr,
  output logic            irq,
  output logic            flag
);
  logic evt;
  assign evt = |src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      flag <= 1'b0;
    end else begin
      irq <= evt;
      if (evt)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_buffer_dp.sv
module frame_buffer_dp #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_i,
  input  logic          protect_i,
  input  logic          ackwait_i,
  input  logic          hw_start_i,
  input  logic          hw_valid_i,
  output logic          hw_ready_o,
  input  logic [DW-1:0] hw_data_i,
  input  logic          hr_start_i,
  input  logic          hr_stop_i,
  output logic          hr_valid_o,
  input  logic          hr_ready_i,
  output logic [DW-1:0] hr_data_o,
  input  logic          rx_start_i,
  input  logic          rx_valid_i,
  output logic          rx_ready_o,
  input  logic [DW-1:0] rx_data_i,
  input  logic          tx_start_i,
  input  logic          tx_stop_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [DW-1:0] tx_data_o,
  input  logic          ur_clr_i,
  output logic          ur_irq_o,
  output logic          ur_flag_o
);
  localparam int AW  = $clog2(DEPTH);
  localparam int NRD = 2;

  fb_pkg::wr_evt_t hw_evt, rx_evt;
  logic [AW-1:0]   hw_addr, rx_addr;
  logic [AW-1:0]   raddr [NRD];
  logic [DW-1:0]   rdata [NRD];
  logic            rx_keep;
  logic            rx_we;
  logic            frame_ok;
  logic            conflict;

  assign rx_keep  = !protect_i && !ackwait_i;
  assign rx_we    = rx_evt.we;
  assign conflict = rx_start_i && rx_keep && hr_valid_o;

  fb_wr_port #(.DEPTH(DEPTH), .DW(DW)) u_hw (
    .clk(clk), .rst_n(rst_n), .sleep(sleep_i),
    .start(hw_start_i), .valid(hw_valid_i), .ready(hw_ready_o),
    .data(hw_data_i), .keep(1'b1), .evt(hw_evt), .addr(hw_addr)
  );

  fb_wr_port #(.DEPTH(DEPTH), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .sleep(sleep_i),
    .start(rx_start_i), .valid(rx_valid_i), .ready(rx_ready_o),
    .data(rx_data_i), .keep(rx_keep), .evt(rx_evt), .addr(rx_addr)
  );

  fb_rd_port #(.DEPTH(DEPTH)) u_hr (
    .clk(clk), .rst_n(rst_n), .sleep(sleep_i),
    .start(hr_start_i), .stop(hr_stop_i), .ready(hr_ready_i),
    .valid(hr_valid_o), .addr(raddr[0])
  );

  fb_rd_port #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .sleep(sleep_i),
    .start(tx_start_i), .stop(tx_stop_i), .ready(tx_ready_i),
    .valid(tx_valid_o), .addr(raddr[1])
  );

  fb_store #(.DEPTH(DEPTH), .DW(DW), .NRD(NRD)) u_mem (
    .clk(clk),
    .a_we(rx_evt.we), .a_addr(rx_addr), .a_data(rx_data_i),
    .b_we(hw_evt.we), .b_addr(hw_addr), .b_data(hw_data_i),
    .frame_ok(frame_ok), .raddr(raddr), .rdata(rdata)
  );

  assign hr_data_o = rdata[0];
  assign tx_data_o = rdata[1];

  // Frame validity: lost on sleep, reset or over-length; gained on a stored length field.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   frame_ok <= 1'b0;
    else if (sleep_i || hw_evt.ovf || rx_evt.ovf) frame_ok <= 1'b0;
    else if (hw_evt.first || rx_evt.first)        frame_ok <= 1'b1;
  end

  fb_underrun #(.NSRC(3)) u_ur (
    .clk(clk), .rst_n(rst_n),
    .src({conflict, rx_evt.ovf, hw_evt.ovf}),
    .clr(ur_clr_i), .irq(ur_irq_o), .flag(ur_flag_o)
  );
endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_i,
  input logic          protect_i,
  input logic          ackwait_i,
  input logic          rx_start_i,
  input logic          hw_ready_o,
  input logic          rx_ready_o,
  input logic          hr_valid_o,
  input logic          tx_valid_o,
  input logic [DW-1:0] hr_data_o,
  input logic [DW-1:0] tx_data_o,
  input logic          ur_clr_i,
  input logic          ur_irq_o,
  input logic          ur_flag_o,
  input logic          frame_ok,
  input logic          rx_we
);
  p_sleep_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> (!hw_ready_o && !rx_ready_o && !hr_valid_o && !tx_valid_o));

  p_sleep_forget_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !frame_ok);

  p_protect_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    protect_i |-> !rx_we);

  p_ackwait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ackwait_i |-> !rx_we);

  p_conflict_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start_i && !sleep_i && !protect_i && !ackwait_i && hr_valid_o) |=> ur_irq_o);

  p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ur_irq_o |-> ur_flag_o);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ur_flag_o && !ur_clr_i) |=> ur_flag_o);

  p_invalid_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |-> (hr_data_o == '0 && tx_data_o == '0));
endmodule

bind frame_buffer_dp fb_checker #(.DW(DW)) u_chk (.*);

// File: tb/frame_buffer_dp_test.sv
module frame_buffer_dp_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_i = 0, protect_i = 0, ackwait_i = 0;
  logic hw_start_i = 0, hw_valid_i = 0; logic [7:0] hw_data_i = 0; logic hw_ready_o;
  logic hr_start_i = 0, hr_stop_i = 0, hr_ready_i = 0; logic hr_valid_o; logic [7:0] hr_data_o;
  logic rx_start_i = 0, rx_valid_i = 0; logic [7:0] rx_data_i = 0; logic rx_ready_o;
  logic tx_start_i = 0, tx_stop_i = 0, tx_ready_i = 0; logic tx_valid_o; logic [7:0] tx_data_o;
  logic ur_clr_i = 0, ur_irq_o, ur_flag_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_buffer_dp uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [128];
  bit model_ok = 0;
  logic [7:0] pat [130];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_byte(input int i);
    return model_ok ? model[i % 128] : 8'h00;
  endfunction

  // Drive n bytes of pat[] on host (radio=0) or receive (radio=1) stream.
  task automatic wr_frame(input bit radio, input int n, input bit stored);
    for (int i = 0; i < n; i++) begin
      if (radio) begin rx_start_i = (i == 0); rx_valid_i = 1; rx_data_i = pat[i]; end
      else       begin hw_start_i = (i == 0); hw_valid_i = 1; hw_data_i = pat[i]; end
      @(negedge clk);
    end
    rx_start_i = 0; rx_valid_i = 0; hw_start_i = 0; hw_valid_i = 0;
    if (stored) begin
      if (pat[0] > 8'd127 || n > 128) model_ok = 0;
      else begin
        for (int i = 0; i < n; i++) model[i] = pat[i];
        model_ok = 1;
      end
    end
  endtask

  task automatic rd_frame(input bit radio, input int n, input string req);
    if (radio) tx_start_i = 1; else hr_start_i = 1;
    @(negedge clk);
    tx_start_i = 0; hr_start_i = 0;
    if (radio) tx_ready_i = 1; else hr_ready_i = 1;
    for (int i = 0; i < n; i++) begin
      check(req, radio ? int'(tx_valid_o) : int'(hr_valid_o), 1);
      check(req, radio ? int'(tx_data_o) : int'(hr_data_o), int'(expect_byte(i)));
      @(negedge clk);
    end
    tx_ready_i = 0; hr_ready_i = 0;
    if (radio) tx_stop_i = 1; else hr_stop_i = 1;
    @(negedge clk);
    tx_stop_i = 0; hr_stop_i = 0;
  endtask

  task automatic fill_pat(input int n);
    pat[0] = 8'(n - 1);
    for (int i = 1; i < n; i++) pat[i] = 8'($urandom);
  endtask

  task automatic clear_flag();
    ur_clr_i = 1; @(negedge clk); ur_clr_i = 0;
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Reset state
    check("R11 flag after reset", ur_flag_o, 0);
    check("R3 write not ready without start", hw_ready_o, 0);
    check("R3 rx not ready without start", rx_ready_o, 0);
    check("R3 read not valid without session", hr_valid_o, 0);
    rd_frame(0, 2, "R11 empty reads zero");

    // Host write and read back
    fill_pat(20); wr_frame(0, 20, 1);
    rd_frame(0, 20, "R1 host write readback");

    // Concurrent host and transmit reads
    hr_start_i = 1; tx_start_i = 1; @(negedge clk);
    hr_start_i = 0; tx_start_i = 0; hr_ready_i = 1; tx_ready_i = 1;
    for (int i = 0; i < 20; i++) begin
      check("R2 host side", hr_data_o, expect_byte(i));
      check("R2 transmit side", tx_data_o, expect_byte(i));
      @(negedge clk);
    end
    hr_ready_i = 0; tx_ready_i = 0; hr_stop_i = 1; tx_stop_i = 1; @(negedge clk);
    hr_stop_i = 0; tx_stop_i = 0;

    // Held read: pointer must not advance without ready
    hr_start_i = 1; @(negedge clk); hr_start_i = 0;
    @(negedge clk); @(negedge clk);
    check("R3 read held at address 0", hr_data_o, expect_byte(0));
    hr_stop_i = 1; @(negedge clk); hr_stop_i = 0;
    check("R3 valid drops after stop", hr_valid_o, 0);

    // Restart part way
    fill_pat(10); wr_frame(0, 10, 1);
    fill_pat(4);  wr_frame(0, 4, 1);
    rd_frame(0, 10, "R12 restart keeps tail");

    // Protect blocks radio storage
    protect_i = 1;
    fill_pat(8); wr_frame(1, 8, 0);
    rd_frame(0, 10, "R7 protect keeps frame");
    check("R7 no interrupt flag", ur_flag_o, 0);
    fill_pat(6); wr_frame(0, 6, 1);
    rd_frame(1, 6, "R8 host write under protect");
    protect_i = 0;

    // Ack-wait blocks radio storage
    ackwait_i = 1;
    fill_pat(12); wr_frame(1, 12, 0);
    rd_frame(1, 6, "R9 ackwait keeps frame");
    ackwait_i = 0;

    // Conflict: reception during host read
    hr_start_i = 1; @(negedge clk); hr_start_i = 0;
    rx_start_i = 1; rx_valid_i = 1; rx_data_i = 8'd3;
    @(negedge clk);
    rx_start_i = 0; rx_valid_i = 0;
    model[0] = 8'd3; model_ok = 1;
    check("R4 conflict pulse", ur_irq_o, 1);
    check("R6 flag set", ur_flag_o, 1);
    @(negedge clk);
    check("R6 pulse one cycle", ur_irq_o, 0);
    check("R6 flag sticky", ur_flag_o, 1);
    hr_stop_i = 1; @(negedge clk); hr_stop_i = 0;
    clear_flag();
    check("R6 flag cleared", ur_flag_o, 0);

    // Protected reception during host read: no conflict
    protect_i = 1;
    hr_start_i = 1; @(negedge clk); hr_start_i = 0;
    rx_start_i = 1; rx_valid_i = 1; rx_data_i = 8'd1; @(negedge clk);
    rx_start_i = 0; rx_valid_i = 0;
    check("R7 no conflict under protect", ur_irq_o, 0);
    hr_stop_i = 1; @(negedge clk); hr_stop_i = 0;
    protect_i = 0;

    // Over-length: length field 128
    pat[0] = 8'd128; pat[1] = 8'h55; pat[2] = 8'hAA;
    hw_start_i = 1; hw_valid_i = 1; hw_data_i = pat[0]; @(negedge clk);
    hw_start_i = 0; hw_valid_i = 0;
    check("R5 length above 127 pulse", ur_irq_o, 1);
    hw_valid_i = 1; hw_data_i = pat[1]; @(negedge clk);
    hw_data_i = pat[2]; @(negedge clk); hw_valid_i = 0;
    model_ok = 0;
    rd_frame(0, 3, "R5 invalid frame reads zero");
    check("R5 flag", ur_flag_o, 1);
    clear_flag();

    // Length 127 is legal
    fill_pat(128); wr_frame(0, 128, 1);
    check("R5 full frame no flag", ur_flag_o, 0);
    rd_frame(1, 128, "R5 full 128 byte frame");

    // 129th byte
    fill_pat(128); pat[128] = 8'h77; wr_frame(1, 129, 1);
    check("R5 129th byte flag", ur_flag_o, 1);
    rd_frame(0, 2, "R5 overlong reads zero");
    clear_flag();

    // Sleep
    fill_pat(5); wr_frame(0, 5, 1);
    hr_start_i = 1; @(negedge clk); hr_start_i = 0;
    sleep_i = 1; hw_start_i = 1; rx_start_i = 1;
    @(negedge clk);
    check("R10 host write refused", hw_ready_o, 0);
    check("R10 rx refused", rx_ready_o, 0);
    check("R10 read refused", hr_valid_o, 0);
    hw_start_i = 0; rx_start_i = 0;
    @(negedge clk); sleep_i = 0; @(negedge clk);
    check("R10 session closed", hr_valid_o, 0);
    model_ok = 0;
    rd_frame(0, 5, "R10 contents lost");

    // Random mix
    for (int k = 0; k < 30; k++) begin
      int n = 1 + int'($urandom % 60);
      bit radio = 1'($urandom);
      bit blk = radio && ($urandom % 4 == 0);
      fill_pat(n);
      protect_i = blk;
      wr_frame(radio, n, !blk);
      protect_i = 0;
      rd_frame(1'($urandom), n, blk ? "R7 random protected" : "R1 random frame");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule